// File: doc/BRIEF.md
# Granular Pause Stall Counter

This unit holds one execution strand stalled for a requested number of clock cycles. A single write carries the requested length. The unit raises `blocked` on the next cycle and keeps it high until the pause runs out. The count is kept in coarse steps. The written value is scaled down by a power of two, set by `GRAN_SHIFT`, and loaded into a step counter. A prescaler lowers that counter once every `2**GRAN_SHIFT` cycles. A request shorter than one step still gives a stall of one cycle.

A trap input ends an ongoing pause early. When the pause ends, by running out or by a trap, `done` pulses for a single cycle. A new write during a pause replaces the running count and restarts the prescaler. Each strand has its own instance.

Top module: `granular_pause_unit`

## Requirements
- R1: In the cycle after a clock edge at which `wr_en` is high, `blocked` is high.
- R2: A write of value V with N = V >> 3 of at least 1 holds `blocked` high for exactly 8*N cycles, measured from the first blocked cycle. This is the default `GRAN_SHIFT` of 3.
- R3: A write of any value below 8, including 0, holds `blocked` high for exactly one cycle.
- R4: If `trap` is high at an edge while `blocked` is high and `wr_en` is low, `blocked` is low in the next cycle.
- R5: `done` is high for exactly one cycle, in the first cycle in which `blocked` is low after a pause ends. This holds both for a pause that runs out and for one cut short by a trap. `done` is low while `blocked` is high.
- R6: A write during a pause replaces the count and restarts the prescaler. The new length is measured from the new write. `blocked` stays high and no `done` pulse occurs at the reload.
- R7: `trap` while no pause is active has no effect: `blocked` and `done` stay low.
- R8: When `wr_en` and `trap` are high at the same edge, the write wins and a full pause of the new length starts.
- R9: While `rst_n` is low, `blocked` and `done` are low.
- R10: The low three bits of the written value are discarded. A write of 23 stalls for 16 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for a pause request |
| wr_val | input | VAL_W | Requested stall length in cycles |
| trap | input | 1 | Disrupting trap; aborts an active pause |
| blocked | output | 1 | Strand stall, high while the pause runs |
| done | output | 1 | One-cycle pulse when a pause ends |

## Verification
The bench measures the exact stall length at the step boundaries: 8, 16 and a value with nonzero low bits. A design that counts one extra tick would stall for 8N+1 cycles, and one that keeps the low bits would stall too long. Writes of 0, 5 and 7 check the one-cycle minimum; a design that treats a zero count as already expired would never raise `blocked`. Traps arrive on the first blocked cycle and in the middle of a long pause, and also while idle. A design that lets a trap act while idle, or lets a trap beat a simultaneous write, shows a spurious `done` or a short stall. A reload in the middle of a pause must give a stall of exactly the new length with no `done`. A prescaler that is not restarted on the reload would end that stall up to seven cycles early.

// File: rtl/granular_pause_pkg.sv
package granular_pause_pkg;
   // Reason the running pause ends at the current edge
   typedef enum logic [1:0] {
      GP_END_NONE   = 2'd0,
      GP_END_EXPIRE = 2'd1,
      GP_END_TRAP   = 2'd2
   } gp_end_e;
endpackage

// File: rtl/gp_prescale.sv
module gp_prescale #(
   parameter int SHIFT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);
   generate
      if (SHIFT == 0) begin : g_every_cycle
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, clear};
         assign tick = run;
      end else begin : g_divided
         localparam logic [SHIFT-1:0] LAST = {SHIFT{1'b1}};
         logic [SHIFT-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (clear) begin
               phase_q <= '0;
            end else if (run) begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick = run && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/gp_stepcount.sv
module gp_stepcount
   import granular_pause_pkg::*;
#(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_steps,
   input  logic          tick,
   input  logic          abort,
   output logic          active,
   output logic          fin
);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] steps_q;
   logic          active_q;
   logic          fin_q;
   gp_end_e       end_c;

   always_comb begin
      end_c = GP_END_NONE;
      if (active_q && !load) begin
         if (abort) begin
            end_c = GP_END_TRAP;
         end else if (steps_q == '0) begin
            end_c = GP_END_EXPIRE;
         end else if (tick && steps_q == ONE) begin
            end_c = GP_END_EXPIRE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         steps_q  <= '0;
         active_q <= 1'b0;
         fin_q    <= 1'b0;
      end else if (load) begin
         steps_q  <= load_steps;
         active_q <= 1'b1;
         fin_q    <= 1'b0;
      end else if (end_c != GP_END_NONE) begin
         steps_q  <= '0;
         active_q <= 1'b0;
         fin_q    <= 1'b1;
      end else begin
         fin_q <= 1'b0;
         if (active_q && tick) begin
            steps_q <= steps_q - ONE;
         end
      end
   end

   assign active = active_q;
   assign fin    = fin_q;
endmodule

// File: rtl/granular_pause_unit.sv
module granular_pause_unit #(
   parameter int VAL_W      = 16,
   parameter int GRAN_SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VAL_W-1:0] wr_val,
   input  logic             trap,
   output logic             blocked,
   output logic             done
);
   localparam int CW = VAL_W - GRAN_SHIFT;

   generate
      if (GRAN_SHIFT < 0 || GRAN_SHIFT > 8) begin : g_bad_shift
         $error("GRAN_SHIFT must be within 0..8");
      end
      if (VAL_W <= GRAN_SHIFT) begin : g_bad_width
         $error("VAL_W must exceed GRAN_SHIFT");
      end
   endgenerate

   logic          tick;
   logic          active;
   logic [CW-1:0] steps_in;

   generate
      if (GRAN_SHIFT == 0) begin : g_noscale
         assign steps_in = wr_val;
      end else begin : g_scale
         logic [GRAN_SHIFT-1:0] dropped_bits;
         assign steps_in     = wr_val[VAL_W-1:GRAN_SHIFT];
         assign dropped_bits = wr_val[GRAN_SHIFT-1:0];
         logic unused_ok;
         assign unused_ok = &{1'b0, dropped_bits};
      end
   endgenerate

   gp_prescale #(.SHIFT(GRAN_SHIFT)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (wr_en),
      .run   (active),
      .tick  (tick)
   );

   gp_stepcount #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_en),
      .load_steps (steps_in),
      .tick       (tick),
      .abort      (trap),
      .active     (active),
      .fin        (done)
   );

   assign blocked = active;
endmodule

// File: rtl/granular_pause_chk.sv
module granular_pause_chk #(
   parameter int VAL_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [VAL_W-1:0] wr_val,
   input logic             trap,
   input logic             blocked,
   input logic             done
);
   logic short_wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) short_wr_q <= 1'b0;
      else        short_wr_q <= wr_en && (wr_val < VAL_W'(8));
   end

   a_r1_block_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> blocked);

   a_r3_short_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (short_wr_q && !wr_en) |=> (!blocked && done));

   a_r4_trap_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && trap && !wr_en) |=> (!blocked && done));

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_done_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !blocked);

   a_r5_done_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(blocked));

   a_r6_reload_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && wr_en) |=> (blocked && !done));

   a_r7_idle_trap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !wr_en) |=> (!blocked && !done));

   a_r8_write_beats_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && trap) |=> (blocked && !done));
endmodule

bind granular_pause_unit granular_pause_chk #(.VAL_W(VAL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_val  (wr_val),
   .trap    (trap),
   .blocked (blocked),
   .done    (done)
);

// File: tb/granular_pause_unit_test.sv
`timescale 1ns/1ps
module granular_pause_unit_test;
   localparam int VAL_W = 16;
   localparam int NV    = 13;
   localparam int LIMIT = 5000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [VAL_W-1:0] wr_val = '0;
   logic             trap = 1'b0;
   logic             blocked;
   logic             done;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   granular_pause_unit #(.VAL_W(VAL_W), .GRAN_SHIFT(3)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val),
      .trap(trap), .blocked(blocked), .done(done)
   );

   // Each entry: {value, trap after k blocked cycles (0 = none), expected length, req}
   localparam logic [51:0] VEC [NV] = '{
      {16'd0,    16'd0,  16'd1,    4'd3},  // R3 zero
      {16'd5,    16'd0,  16'd1,    4'd3},  // R3
      {16'd7,    16'd0,  16'd1,    4'd3},  // R3 largest short value
      {16'd8,    16'd0,  16'd8,    4'd2},  // R2 one step
      {16'd16,   16'd0,  16'd16,   4'd2},  // R2
      {16'd23,   16'd0,  16'd16,   4'd10}, // R10 low bits dropped
      {16'd64,   16'd0,  16'd64,   4'd2},  // R2
      {16'd200,  16'd0,  16'd200,  4'd2},  // R2
      {16'd1000, 16'd0,  16'd1000, 4'd2},  // R2 long pause
      {16'd24,   16'd5,  16'd5,    4'd4},  // R4 trap mid pause
      {16'd80,   16'd30, 16'd30,   4'd4},  // R4
      {16'd100,  16'd1,  16'd1,    4'd4},  // R4 trap on first blocked cycle
      {16'd3,    16'd1,  16'd1,    4'd4}   // R4 trap during short pause
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_write(input int val, input bit with_trap);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_val = VAL_W'(val);
      trap   = with_trap;
      @(negedge clk);
      wr_en  = 1'b0;
      trap   = 1'b0;
   endtask

   // Called at the negedge just after the write edge
   task automatic measure(input int trap_off, input int exp, input string req);
      int len = 0;
      int bad_done = 0;
      while (blocked && len < LIMIT) begin
         len++;
         if (done) bad_done++;
         if (trap_off != 0 && len == trap_off) trap = 1'b1;
         @(negedge clk);
         trap = 1'b0;
      end
      check(len == exp, req, len, exp);
      check(bad_done == 0, "R5 done during block", bad_done, 0);
      check(done === 1'b1, "R5 done pulse", int'(done), 1);
      @(negedge clk);
      check(done === 1'b0, "R5 done width", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(blocked === 1'b0, "R9 blocked in reset", int'(blocked), 0);
      check(done === 1'b0, "R9 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         do_write(int'(VEC[i][51:36]), 1'b0);
         check(blocked === 1'b1, "R1 blocked after write", int'(blocked), 1);
         measure(int'(VEC[i][35:20]), int'(VEC[i][19:4]),
                 $sformatf("R%0d length v=%0d", VEC[i][3:0], VEC[i][51:36]));
      end

      // R7: trap while idle
      trap = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(blocked === 1'b0 && done === 1'b0, "R7 idle trap",
               int'({blocked, done}), 0);
      end
      trap = 1'b0;

      // R6: reload mid pause
      do_write(80, 1'b0);
      repeat (19) @(negedge clk);
      check(blocked === 1'b1, "R6 still blocked before reload", int'(blocked), 1);
      do_write(16, 1'b0);
      check(done === 1'b0, "R6 no done at reload", int'(done), 0);
      measure(0, 16, "R6 reload length");

      // R8: write and trap together, during a pause and while idle
      do_write(40, 1'b0);
      repeat (3) @(negedge clk);
      do_write(16, 1'b1);
      check(done === 1'b0, "R8 no done", int'(done), 0);
      measure(0, 16, "R8 active write+trap");
      do_write(8, 1'b1);
      measure(0, 8, "R8 idle write+trap");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule